// File: doc/BRIEF.md
# Vectored Interrupt Controller with Word-Register Bus

This block gathers up to 32 interrupt request lines into one processor interrupt. Each line is fixed at build time as edge-sensitive or level-sensitive. When hardware capture is on, line activity is latched into a status register. Status is masked by an enable register to give a pending set. The lowest-numbered pending line is reported as a vector. A single output line tells the processor that something is pending.

Software reaches eight 32-bit registers through a simple synchronous word bus. The bus has a write strobe, a 3-bit word offset and write data, and read data is combinational on the offset. Interrupts are acknowledged through a write-only location. Enables are set or cleared atomically through two more write-only locations. A two-bit master register separates output gating from hardware capture. While capture is off, software may write status directly to raise test interrupts.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, status, enable and master read 0, pending reads 0, the vector (offset 6) reads 0xFFFFFFFF and `irq_out` is low.
- R2: A write to offset 0 (status) loads status when master bit 1 is clear. The same write is ignored when master bit 1 is set.
- R3: Offset 1 reads pending, which is status AND enable at all times. Writes to offset 1 have no effect.
- R4: Offset 6 reads the index of the lowest-numbered set pending bit. Bit 0 has the highest priority. With nothing pending it reads 0xFFFFFFFF, and writes to it have no effect.
- R5: `irq_out` is high exactly when master bit 0 is set and pending is nonzero.
- R6: A write to offset 3 (acknowledge) clears each status bit whose data bit is 1.
- R7: A write to offset 4 ORs the data into enable. A write to offset 5 clears each enable bit whose data bit is 1. Offset 2 reads enable, and offsets 3, 4 and 5 read 0.
- R8: A write to offset 7 (master) keeps only data bits 1:0. Bit 0 gates the output and bit 1 enables hardware capture, and the upper bits read 0.
- R9: While master bit 1 is set, a level-sensitive line that is high sets its status bit at every clock. Acknowledging the bit while the line stays high leaves it set.
- R10: While master bit 1 is set, an edge-sensitive line sets its status bit on a clock where it is 1 and was 0 on the previous clock. Rising edges seen while bit 1 is clear are lost, and a line held high does not set the bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and capture clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 3 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_src | input | N_IRQ | Interrupt request lines, synchronous to `clk` |
| irq_out | output | 1 | Interrupt to the processor |

## Verification
The bench acknowledges a level line while it is still high. A design that cleared the bit for good would let that interrupt slip away. It holds an edge line high across an acknowledge to show that the bit is not set again; a design that treated edge lines as levels would raise the interrupt over and over. It pulses an edge line while capture is off, writes status while capture is on, and writes the computed pending and vector locations. Each of these must leave the visible state unchanged. It also loads status with the highest and a middle bit together to confirm that the lower index wins, then acknowledges that bit so the vector falls to the other one.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        OFS_STATUS = 3'd0,
        OFS_PEND   = 3'd1,
        OFS_ENABLE = 3'd2,
        OFS_ACK    = 3'd3,
        OFS_SETEN  = 3'd4,
        OFS_CLREN  = 3'd5,
        OFS_VECTOR = 3'd6,
        OFS_MASTER = 3'd7
    } reg_ofs_e;

    localparam int MST_OUT_BIT = 0;
    localparam int MST_HW_BIT  = 1;
endpackage

// File: rtl/intc_capture.sv
module intc_capture #(
    parameter int             N    = 32,
    parameter logic [N-1:0]   KIND = '0
) (
    input  logic [N-1:0] line_now,
    input  logic [N-1:0] line_prev,
    output logic [N-1:0] set_mask
);
    for (genvar i = 0; i < N; i++) begin : g_line
        if (KIND[i]) begin : g_edge
            assign set_mask[i] = line_now[i] & ~line_prev[i];
        end else begin : g_level
            assign set_mask[i] = line_now[i];
        end
    end
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
    parameter int N  = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  pend,
    output logic          found,
    output logic [IW-1:0] index
);
    always_comb begin
        found = 1'b0;
        index = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                found = 1'b1;
                index = i[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import intc_pkg::*;
#(
    parameter int               N_IRQ     = 32,
    parameter logic [N_IRQ-1:0] EDGE_KIND = 32'hFFFF_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    input  logic [N_IRQ-1:0]    irq_src,
    output logic                irq_out
);
    localparam int IW = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

    typedef struct packed {
        logic [N_IRQ-1:0] status;
        logic [N_IRQ-1:0] enable;
        logic [1:0]       master;
        logic [N_IRQ-1:0] prev;
    } ctrl_state_t;

    ctrl_state_t state_d, state_q;

    logic [N_IRQ-1:0] hw_set;
    logic [N_IRQ-1:0] pend;
    logic             pend_found;
    logic [IW-1:0]    pend_index;
    logic [REG_W-1:0] vector;
    logic [N_IRQ-1:0] wmask;

    intc_capture #(.N(N_IRQ), .KIND(EDGE_KIND)) u_capture (
        .line_now  (irq_src),
        .line_prev (state_q.prev),
        .set_mask  (hw_set)
    );

    assign pend = state_q.status & state_q.enable;

    intc_prio #(.N(N_IRQ)) u_prio (
        .pend  (pend),
        .found (pend_found),
        .index (pend_index)
    );

    always_comb begin
        vector = '1;
        if (pend_found) begin
            vector = '0;
            vector[IW-1:0] = pend_index;
        end
    end

    assign wmask = bus_wdata[N_IRQ-1:0];

    always_comb begin
        state_d      = state_q;
        state_d.prev = irq_src;
        if (bus_we) begin
            case (reg_ofs_e'(bus_addr))
                OFS_STATUS: if (!state_q.master[MST_HW_BIT]) state_d.status = wmask;
                OFS_ACK:    state_d.status = state_q.status & ~wmask;
                OFS_SETEN:  state_d.enable = state_q.enable | wmask;
                OFS_CLREN:  state_d.enable = state_q.enable & ~wmask;
                OFS_MASTER: state_d.master = bus_wdata[1:0];
                default:    ;
            endcase
        end
        if (state_q.master[MST_HW_BIT]) begin
            state_d.status = state_d.status | hw_set;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (reg_ofs_e'(bus_addr))
            OFS_STATUS: bus_rdata[N_IRQ-1:0] = state_q.status;
            OFS_PEND:   bus_rdata[N_IRQ-1:0] = pend;
            OFS_ENABLE: bus_rdata[N_IRQ-1:0] = state_q.enable;
            OFS_VECTOR: bus_rdata = vector;
            OFS_MASTER: bus_rdata[1:0] = state_q.master;
            default:    bus_rdata = '0;
        endcase
    end

    assign irq_out = state_q.master[MST_OUT_BIT] & (|pend);
endmodule

// File: rtl/intc_checker.sv
module intc_checker
    import intc_pkg::*;
#(
    parameter int             N    = 32,
    parameter logic [N-1:0]   KIND = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic [REG_W-1:0]  bus_rdata,
    input logic [N-1:0]      irq_src,
    input logic              irq_out,
    input logic [N-1:0]      status,
    input logic [N-1:0]      enable,
    input logic [1:0]        master,
    input logic [REG_W-1:0]  vector
);
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_ACK && !master[MST_HW_BIT])
        |=> ((status & $past(bus_wdata[N-1:0])) == '0));

    p_status_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_STATUS && master[MST_HW_BIT] && irq_src == '0)
        |=> $stable(status));

    p_level_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (master[MST_HW_BIT] && ((irq_src & ~KIND) != '0))
        |=> ((status & $past(irq_src & ~KIND)) == $past(irq_src & ~KIND)));

    p_set_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_SETEN)
        |=> ((enable & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0])));

    p_vector_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & enable) == '0) |-> (vector == '1));

    p_out_needs_master_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (master[MST_OUT_BIT] && vector != '1));

    p_master_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_MASTER) |-> (bus_rdata[REG_W-1:2] == '0));
endmodule

bind irq_vector_ctrl intc_checker #(.N(N_IRQ), .KIND(EDGE_KIND)) u_intc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_src   (irq_src),
    .irq_out   (irq_out),
    .status    (state_q.status),
    .enable    (state_q.enable),
    .master    (state_q.master),
    .vector    (vector)
);

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_src = '0;
    logic        irq_out;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    irq_vector_ctrl #(.N_IRQ(32), .EDGE_KIND(32'hFFFF_0000)) i_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_src(irq_src), .irq_out(irq_out)
    );

    typedef struct packed {
        logic        we;
        logic [2:0]  wa;
        logic [31:0] wd;
        logic [31:0] lines;
        logic [2:0]  ra;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic [3:0]  req;
    } step_t;

    localparam int NSTEP = 29;
    localparam step_t STEPS [NSTEP] = '{
        '{1'b1, 3'd0, 32'h5,     32'h0,     3'd0, 32'h5,        1'b0, 4'd2},  // R2 load
        '{1'b1, 3'd4, 32'h4,     32'h0,     3'd2, 32'h4,        1'b0, 4'd7},  // R7 set
        '{1'b0, 3'd0, 32'h0,     32'h0,     3'd1, 32'h4,        1'b0, 4'd3},  // R3 and
        '{1'b0, 3'd0, 32'h0,     32'h0,     3'd6, 32'h2,        1'b0, 4'd4},  // R4
        '{1'b1, 3'd7, 32'h1,     32'h0,     3'd1, 32'h4,        1'b1, 4'd5},  // R5 on
        '{1'b1, 3'd5, 32'h4,     32'h0,     3'd2, 32'h0,        1'b0, 4'd7},  // R7 clear
        '{1'b1, 3'd4, 32'h5,     32'h0,     3'd6, 32'h0,        1'b1, 4'd4},  // R4 bit0 wins
        '{1'b1, 3'd3, 32'h1,     32'h0,     3'd6, 32'h2,        1'b1, 4'd6},  // R6
        '{1'b1, 3'd3, 32'h4,     32'h0,     3'd6, 32'hFFFF_FFFF,1'b0, 4'd6},  // R6 all gone
        '{1'b1, 3'd7, 32'hFF,    32'h0,     3'd7, 32'h3,        1'b0, 4'd8},  // R8 two bits
        '{1'b1, 3'd0, 32'hFF,    32'h0,     3'd0, 32'h0,        1'b0, 4'd2},  // R2 locked
        '{1'b0, 3'd0, 32'h0,     32'h8,     3'd0, 32'h8,        1'b0, 4'd9},  // R9 latch
        '{1'b1, 3'd3, 32'h8,     32'h8,     3'd0, 32'h8,        1'b0, 4'd9},  // R9 reset
        '{1'b0, 3'd0, 32'h0,     32'h0,     3'd0, 32'h8,        1'b0, 4'd9},  // R9 sticky
        '{1'b1, 3'd3, 32'h8,     32'h0,     3'd0, 32'h0,        1'b0, 4'd6},
        '{1'b0, 3'd0, 32'h0,     32'h1_0000,3'd0, 32'h1_0000,   1'b0, 4'd10}, // R10 edge
        '{1'b1, 3'd3, 32'h1_0000,32'h1_0000,3'd0, 32'h0,        1'b0, 4'd10}, // R10 held
        '{1'b1, 3'd4, 32'h1_0000,32'h1_0000,3'd1, 32'h0,        1'b0, 4'd10},
        '{1'b0, 3'd0, 32'h0,     32'h0,     3'd0, 32'h0,        1'b0, 4'd10},
        '{1'b0, 3'd0, 32'h0,     32'h1_0000,3'd1, 32'h1_0000,   1'b1, 4'd10},
        '{1'b0, 3'd0, 32'h0,     32'h1_0000,3'd6, 32'h10,       1'b1, 4'd4},
        '{1'b1, 3'd7, 32'h1,     32'h0,     3'd7, 32'h1,        1'b1, 4'd8},
        '{1'b1, 3'd3, 32'h1_0000,32'h0,     3'd0, 32'h0,        1'b0, 4'd6},
        '{1'b0, 3'd0, 32'h0,     32'h1_0000,3'd0, 32'h0,        1'b0, 4'd10}, // R10 lost
        '{1'b0, 3'd0, 32'h0,     32'h8,     3'd0, 32'h0,        1'b0, 4'd9},
        '{1'b0, 3'd0, 32'h0,     32'h0,     3'd3, 32'h0,        1'b0, 4'd7},
        '{1'b1, 3'd1, 32'hFFFF,  32'h0,     3'd1, 32'h0,        1'b0, 4'd3},  // R3 ro
        '{1'b1, 3'd6, 32'h5,     32'h0,     3'd6, 32'hFFFF_FFFF,1'b0, 4'd4},
        '{1'b0, 3'd0, 32'h0,     32'h0,     3'd4, 32'h0,        1'b0, 4'd7}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_check("R1", 3'd0, 32'h0);
        rd_check("R1", 3'd2, 32'h0);
        rd_check("R1", 3'd7, 32'h0);
        rd_check("R1", 3'd6, 32'hFFFF_FFFF);
        check("R1", {31'b0, irq_out}, 32'h0);

        for (int k = 0; k < NSTEP; k++) begin
            irq_src   = STEPS[k].lines;
            bus_we    = STEPS[k].we;
            bus_addr  = STEPS[k].wa;
            bus_wdata = STEPS[k].wd;
            @(posedge clk); @(negedge clk);
            bus_we   = 1'b0;
            bus_addr = STEPS[k].ra;
            #1;
            check($sformatf("R%0d step %0d rd", STEPS[k].req, k), bus_rdata, STEPS[k].exp_rd);
            check($sformatf("R%0d step %0d irq", STEPS[k].req, k), {31'b0, irq_out},
                  {31'b0, STEPS[k].exp_irq});
        end

        // R4 priority across far-apart bits, master bit 1 clear here
        irq_src = '0;
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd0, 32'h8000_0100);
        rd_check("R4", 3'd6, 32'd8);
        check("R5", {31'b0, irq_out}, 32'h1);
        wr(3'd3, 32'h0000_0100);
        rd_check("R4", 3'd6, 32'd31);
        wr(3'd3, 32'h8000_0000);
        rd_check("R4", 3'd6, 32'hFFFF_FFFF);
        check("R5", {31'b0, irq_out}, 32'h0);

        // R1 reset in mid-run
        wr(3'd0, 32'h0000_0003);
        wr(3'd7, 32'h3);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        rd_check("R1", 3'd0, 32'h0);
        rd_check("R1", 3'd2, 32'h0);
        rd_check("R1", 3'd7, 32'h0);
        check("R1", {31'b0, irq_out}, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule